// File: doc/BRIEF.md
# Zero-Suppressing Sample Capture Controller

This block sits between a fast flash converter and an external 256-entry capture memory. Each clock cycle it takes two 8-bit samples: the one taken earlier in the cycle and the one taken later. Two consecutive cycles are packed into one 4-sample word, so one word forms every second clock. Each word is labelled with the value of a free-running 8-bit word counter (the tag) and with 8 flag bits. The write address advances only when a word is kept. Because of this, the stored tags are sparse, and software rebuilds the absolute time from them.

A word is kept in any of these cases:
- one of its samples is above the threshold;
- the word before it or the word after it has a sample above the threshold;
- its tag is zero, meaning the tag counter has just wrapped;
- a trigger arrived while the word was being assembled.

The memory is a ring, and new words overwrite the oldest ones. Once the trigger word is written, the block goes on recording for a programmable number of tag-counter periods. It then freezes: writes stop, a done flag goes high, and the address of the last write is held so the contents can be read out. A rearm pulse resumes recording from that address.

Top module: `zs_capture_top`

## Requirements
- R1: Word k is built from the samples of cycles 2k and 2k+1, counted from the first clock after reset is released. Its data field is `{smp_b(2k+1), smp_a(2k+1), smp_b(2k), smp_a(2k)}`, with sample 0 in bits 7:0.
- R2: The tag of word k is k modulo 256. The tag is stored in `wr_data[39:32]`.
- R3: A sample is above threshold when its value is greater than 7. A word containing any such sample is written. A value of exactly 7 does not, on its own, cause a write.
- R4: A word is also written if the word just before it or the word just after it has a sample above threshold.
- R5: Every word whose tag is 0 is written unless the block is frozen.
- R6: A trigger pulse seen in either cycle of a word's assembly marks that word, and the marked word is written unless the block is frozen.
- R7: The flags are `wr_data[47:40]`, laid out as follows:
  - bit 40: the word has a sample above threshold;
  - bit 41: trigger mark;
  - bit 42: tag is 0;
  - bit 43: the write happened during the post-trigger span;
  - bits 47:44: per-sample above-threshold mask, with sample 0 in bit 44.
- R8: Each write advances `wr_addr_a` and `wr_addr_b` by one, modulo 256. The address is unchanged in every cycle with no write. The two outputs are always equal, and the first write after reset goes to address 0.
- R9: When a trigger-marked word is written outside the post-trigger span, the block records until `post_periods` more tag-0 words have been written. If `post_periods` is 0, the trigger word itself is the last write. After the last write, `done` goes high in the same cycle as that write's `wr_en`.
- R10: While `done` is high there are no writes, and triggers and samples have no effect. A `rearm` pulse clears `done` and resumes recording from the held address. A `rearm` pulse at any other time is ignored.
- R11: The write for word k, if it happens, shows on the outputs right after the clock edge that ends cycle 2k+4.
- R12: During reset, `wr_en` and `done` are 0 and both address outputs read 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word-pair clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_a | input | 8 | Earlier sample of the cycle |
| smp_b | input | 8 | Later sample of the cycle |
| trig_sync | input | 1 | Trigger synchronization pulse |
| rearm | input | 1 | Leave the frozen state and resume capture |
| post_periods | input | 8 | Tag-counter periods to record after the trigger word |
| wr_en | output | 1 | Memory write strobe |
| wr_data | output | 48 | Flags, tag and 4 samples |
| wr_addr_a | output | 8 | Write address, bank A |
| wr_addr_b | output | 8 | Write address, bank B |
| done | output | 1 | Capture complete, memory frozen |

## Verification
The keep decision for a word needs to see the word after it, so the earliest a write can appear is after the edge that ends cycle 2k+4. That edge comes two cycles after the last sample of the following word has been taken. The bench's model makes each decision in cycle 2k+4 and stamps the expected entry with that cycle number. A monitor samples the outputs one time unit after each rising edge and checks that every write arrives on exactly its stamped edge. The `done` flag is checked in the same sample as the write that ends the span, and a `rearm` takes effect on the edge it is presented on.

// File: rtl/zsc_pkg.sv
// Package: shared widths, flag positions and control states of the
// zero-suppressing capture controller.
package zsc_pkg;

    localparam int SMP_W      = 8;   // bits per sample
    localparam int LANES      = 2;   // samples presented per clock
    localparam int CYC_PER_WD = 2;   // clocks per stored word
    localparam int TAG_W      = 8;   // word-counter tag width
    localparam int ADDR_W     = 8;   // capture memory address width
    localparam int THRESH     = 7;   // sample counts as signal above this

    // Flag bit positions inside the flag byte
    localparam int FL_HIT   = 0;
    localparam int FL_TRIG  = 1;
    localparam int FL_WRAP  = 2;
    localparam int FL_POST  = 3;
    localparam int FL_MASK0 = 4;

    typedef enum logic [1:0] {
        CAP_ARMED  = 2'd0,
        CAP_POST   = 2'd1,
        CAP_FROZEN = 2'd2
    } cap_state_e;

endpackage

// File: rtl/zsc_demux.sv
// Module: zsc_demux
// Packs the two-samples-per-clock stream into words of LANES*CYC_PER_WD
// samples, one word every second clock, and labels each word with a
// free-running tag and a trigger mark.
// Assumes: phase 0 is the first clock after reset release; a trigger
// pulse in either clock of a word's assembly marks that word.
module zsc_demux #(
    parameter int SW    = zsc_pkg::SMP_W,
    parameter int LN    = zsc_pkg::LANES,
    parameter int TW    = zsc_pkg::TAG_W,
    localparam int PAIR_W = SW * LN,
    localparam int WORD_W = PAIR_W * 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAIR_W-1:0] pair_in,
    input  logic              trig_in,
    output logic              word_vld,
    output logic [WORD_W-1:0] word_data,
    output logic [TW-1:0]     word_tag,
    output logic              word_trig
);

    logic              phase_q;
    logic [PAIR_W-1:0] hold_q;
    logic              trig_pend_q;
    logic [TW-1:0]     timer_q;
    logic              vld_q;
    logic [WORD_W-1:0] data_q;
    logic [TW-1:0]     tag_q;
    logic              wtrig_q;

    // Phase toggles every clock: 0 = first pair, 1 = second pair
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= ~phase_q;
    end

    // Hold the first pair and any trigger seen with it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q      <= '0;
            trig_pend_q <= 1'b0;
        end else if (!phase_q) begin
            hold_q      <= pair_in;
            trig_pend_q <= trig_in;
        end
    end

    // Complete the word on the second pair and stamp it with the timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q   <= 1'b0;
            data_q  <= '0;
            tag_q   <= '0;
            wtrig_q <= 1'b0;
            timer_q <= '0;
        end else begin
            vld_q <= phase_q;
            if (phase_q) begin
                data_q  <= {pair_in, hold_q};
                tag_q   <= timer_q;
                wtrig_q <= trig_pend_q | trig_in;
                timer_q <= timer_q + 1'b1;
            end
        end
    end

    assign word_vld  = vld_q;
    assign word_data = data_q;
    assign word_tag  = tag_q;
    assign word_trig = wtrig_q;

    // R1
    word_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld);

    // R2
    tag_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && $past(word_vld, 2)) |-> (word_tag == TW'($past(word_tag, 2) + 1'b1)));

endmodule

// File: rtl/zsc_suppress.sv
// Module: zsc_suppress
// One-word delay line that decides whether the held word is kept: any
// sample above threshold in it or in either neighbour, a zero tag, or a
// trigger mark. The decision is presented when the next word arrives.
// Assumes: word_vld pulses at most every other clock.
module zsc_suppress #(
    parameter int SW     = zsc_pkg::SMP_W,
    parameter int SPW    = 4,
    parameter int TW     = zsc_pkg::TAG_W,
    parameter int THRESH = zsc_pkg::THRESH,
    localparam int WORD_W = SW * SPW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word_data,
    input  logic [TW-1:0]     word_tag,
    input  logic              word_trig,
    output logic              dec_vld,
    output logic              dec_keep,
    output logic [WORD_W-1:0] dec_data,
    output logic [TW-1:0]     dec_tag,
    output logic              dec_trig,
    output logic              dec_wrap,
    output logic              dec_hit,
    output logic [SPW-1:0]    dec_mask
);

    logic [SPW-1:0]    new_mask;
    logic              new_hit;
    logic              cur_vld_q;
    logic [WORD_W-1:0] cur_data_q;
    logic [TW-1:0]     cur_tag_q;
    logic              cur_trig_q;
    logic [SPW-1:0]    cur_mask_q;
    logic              prev_hit_q;

    // Per-sample threshold compare on the incoming word
    for (genvar i = 0; i < SPW; i++) begin : g_cmp
        assign new_mask[i] = (word_data[i*SW +: SW] > SW'(THRESH));
    end
    assign new_hit = |new_mask;

    // Shift the delay line by one word on every new word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_vld_q  <= 1'b0;
            cur_data_q <= '0;
            cur_tag_q  <= '0;
            cur_trig_q <= 1'b0;
            cur_mask_q <= '0;
            prev_hit_q <= 1'b0;
        end else if (word_vld) begin
            cur_vld_q  <= 1'b1;
            cur_data_q <= word_data;
            cur_tag_q  <= word_tag;
            cur_trig_q <= word_trig;
            cur_mask_q <= new_mask;
            prev_hit_q <= cur_vld_q & (|cur_mask_q);
        end
    end

    // Keep decision for the held word, valid with its successor
    always_comb begin
        dec_vld  = word_vld & cur_vld_q;
        dec_hit  = |cur_mask_q;
        dec_wrap = (cur_tag_q == '0);
        dec_keep = dec_hit | prev_hit_q | new_hit | dec_wrap | cur_trig_q;
    end

    assign dec_data = cur_data_q;
    assign dec_tag  = cur_tag_q;
    assign dec_trig = cur_trig_q;
    assign dec_mask = cur_mask_q;

    // R5
    wrap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && dec_tag == '0) |-> dec_keep);

    // R6
    trig_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && dec_trig) |-> dec_keep);

endmodule

// File: rtl/zsc_capctl.sv
// Module: zsc_capctl
// Issues memory writes for kept words, keeps NBANK identical ring
// addresses, and runs the armed / post-trigger / frozen sequence.
// Assumes: post_periods is steady while a trigger word is being written.
module zsc_capctl #(
    parameter int SW     = zsc_pkg::SMP_W,
    parameter int SPW    = 4,
    parameter int TW     = zsc_pkg::TAG_W,
    parameter int AW     = zsc_pkg::ADDR_W,
    parameter int PW     = 8,
    parameter int NBANK  = 2,
    localparam int WORD_W = SW * SPW,
    localparam int FW     = SPW + zsc_pkg::FL_MASK0,
    localparam int DW     = FW + TW + WORD_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       dec_vld,
    input  logic                       dec_keep,
    input  logic [WORD_W-1:0]          dec_data,
    input  logic [TW-1:0]              dec_tag,
    input  logic                       dec_trig,
    input  logic                       dec_wrap,
    input  logic                       dec_hit,
    input  logic [SPW-1:0]             dec_mask,
    input  logic [PW-1:0]              post_periods,
    input  logic                       rearm,
    output logic                       wr_en,
    output logic [DW-1:0]              wr_data,
    output logic [NBANK-1:0][AW-1:0]   wr_addr,
    output logic                       done
);
    import zsc_pkg::*;

    cap_state_e      state_q;
    logic [PW-1:0]   remain_q;
    logic            do_wr;
    logic [FW-1:0]   flags;
    logic            wr_en_q;
    logic [DW-1:0]   wr_data_q;
    logic [AW-1:0]   addr_q [NBANK];

    // Write when kept and not frozen; assemble the flag byte
    always_comb begin
        do_wr                = dec_vld & dec_keep & (state_q != CAP_FROZEN);
        flags                = '0;
        flags[FL_HIT]        = dec_hit;
        flags[FL_TRIG]       = dec_trig;
        flags[FL_WRAP]       = dec_wrap;
        flags[FL_POST]       = (state_q == CAP_POST);
        flags[FW-1:FL_MASK0] = dec_mask;
    end

    // Register the write strobe and the stored word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en_q   <= 1'b0;
            wr_data_q <= '0;
        end else begin
            wr_en_q <= do_wr;
            if (do_wr) wr_data_q <= {flags, dec_tag, dec_data};
        end
    end

    // One ring address per bank, advanced only by a write
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n)     addr_q[b] <= '1;
            else if (do_wr) addr_q[b] <= addr_q[b] + 1'b1;
        end
        assign wr_addr[b] = addr_q[b];
    end

    // Capture sequence: armed, counting post-trigger wraps, frozen
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= CAP_ARMED;
            remain_q <= '0;
        end else begin
            case (state_q)
                CAP_ARMED: begin
                    if (do_wr && dec_trig) begin
                        remain_q <= post_periods;
                        state_q  <= (post_periods == '0) ? CAP_FROZEN : CAP_POST;
                    end
                end
                CAP_POST: begin
                    if (do_wr && dec_wrap) begin
                        remain_q <= remain_q - 1'b1;
                        if (remain_q <= PW'(1)) state_q <= CAP_FROZEN;
                    end
                end
                CAP_FROZEN: begin
                    if (rearm) state_q <= CAP_ARMED;
                end
                default: state_q <= CAP_ARMED;
            endcase
        end
    end

    assign wr_en   = wr_en_q;
    assign wr_data = wr_data_q;
    assign done    = (state_q == CAP_FROZEN);

    // R8
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr[0] == AW'($past(wr_addr[0]) + 1'b1)));

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> $stable(wr_addr[0]));

    // R8
    bank_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_addr[0] == wr_addr[NBANK-1]);

    // R10
    frozen_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |-> !wr_en);

    // R10
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !rearm) |=> done);

endmodule

// File: rtl/zs_capture_top.sv
// Module: zs_capture_top
// Zero-suppressing capture controller: demultiplexer, suppression delay
// line and write/sequence control for a two-bank ring memory.
// Assumes: smp_a is the earlier sample of each clock, smp_b the later.
module zs_capture_top #(
    parameter int SW     = zsc_pkg::SMP_W,
    parameter int TW     = zsc_pkg::TAG_W,
    parameter int AW     = zsc_pkg::ADDR_W,
    parameter int PW     = 8,
    parameter int THRESH = zsc_pkg::THRESH,
    localparam int SPW    = zsc_pkg::LANES * zsc_pkg::CYC_PER_WD,
    localparam int WORD_W = SW * SPW,
    localparam int DW     = SPW + zsc_pkg::FL_MASK0 + TW + WORD_W,
    localparam int NBANK  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] smp_a,
    input  logic [SW-1:0] smp_b,
    input  logic          trig_sync,
    input  logic          rearm,
    input  logic [PW-1:0] post_periods,
    output logic          wr_en,
    output logic [DW-1:0] wr_data,
    output logic [AW-1:0] wr_addr_a,
    output logic [AW-1:0] wr_addr_b,
    output logic          done
);

    logic                     word_vld;
    logic [WORD_W-1:0]        word_data;
    logic [TW-1:0]            word_tag;
    logic                     word_trig;
    logic                     dec_vld, dec_keep, dec_trig, dec_wrap, dec_hit;
    logic [WORD_W-1:0]        dec_data;
    logic [TW-1:0]            dec_tag;
    logic [SPW-1:0]           dec_mask;
    logic [NBANK-1:0][AW-1:0] addr_bus;

    zsc_demux #(.SW(SW), .LN(zsc_pkg::LANES), .TW(TW)) i_demux (
        .clk       (clk),
        .rst_n     (rst_n),
        .pair_in   ({smp_b, smp_a}),
        .trig_in   (trig_sync),
        .word_vld  (word_vld),
        .word_data (word_data),
        .word_tag  (word_tag),
        .word_trig (word_trig)
    );

    zsc_suppress #(.SW(SW), .SPW(SPW), .TW(TW), .THRESH(THRESH)) i_suppress (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_vld  (word_vld),
        .word_data (word_data),
        .word_tag  (word_tag),
        .word_trig (word_trig),
        .dec_vld   (dec_vld),
        .dec_keep  (dec_keep),
        .dec_data  (dec_data),
        .dec_tag   (dec_tag),
        .dec_trig  (dec_trig),
        .dec_wrap  (dec_wrap),
        .dec_hit   (dec_hit),
        .dec_mask  (dec_mask)
    );

    zsc_capctl #(.SW(SW), .SPW(SPW), .TW(TW), .AW(AW), .PW(PW), .NBANK(NBANK)) i_capctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .dec_vld      (dec_vld),
        .dec_keep     (dec_keep),
        .dec_data     (dec_data),
        .dec_tag      (dec_tag),
        .dec_trig     (dec_trig),
        .dec_wrap     (dec_wrap),
        .dec_hit      (dec_hit),
        .dec_mask     (dec_mask),
        .post_periods (post_periods),
        .rearm        (rearm),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .wr_addr      (addr_bus),
        .done         (done)
    );

    assign wr_addr_a = addr_bus[0];
    assign wr_addr_b = addr_bus[1];

endmodule

// File: tb/test_zs_capture_top.sv
module test_zs_capture_top;

    localparam int MAXC = 16000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  smp_a = '0, smp_b = '0;
    logic        trig_sync = 1'b0, rearm = 1'b0;
    logic [7:0]  post_periods = 8'd1;
    logic        wr_en, done;
    logic [47:0] wr_data;
    logic [7:0]  wr_addr_a, wr_addr_b;

    always #5 clk = ~clk;

    zs_capture_top i_zs_capture_top (
        .clk(clk), .rst_n(rst_n), .smp_a(smp_a), .smp_b(smp_b),
        .trig_sync(trig_sync), .rearm(rearm), .post_periods(post_periods),
        .wr_en(wr_en), .wr_data(wr_data), .wr_addr_a(wr_addr_a),
        .wr_addr_b(wr_addr_b), .done(done)
    );

    typedef struct {
        int          stamp;
        logic [7:0]  addr;
        logic [47:0] data;
    } exp_t;

    int   n_chk = 0, n_fail = 0;
    int   cyc = 0, edge_idx = 0;
    bit   mon_on = 1'b0;
    logic [7:0] wa [MAXC];
    logic [7:0] wb [MAXC];
    logic       tcyc [MAXC];
    logic       wtrig [MAXC/2];
    int         m_state = 0;     // 0 armed, 1 post span, 2 frozen
    int         m_remain = 0;
    logic [7:0] m_addr = 8'hFF;
    exp_t       eq[$];
    exp_t       e;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] smp(input int k, input int i);
        case (i)
            0: return wa[2*k];
            1: return wb[2*k];
            2: return wa[2*k+1];
            default: return wb[2*k+1];
        endcase
    endfunction

    function automatic logic [3:0] mask_of(input int k);
        logic [3:0] m;
        for (int i = 0; i < 4; i++) m[i] = (smp(k, i) > 8'd7);
        return m;
    endfunction

    // Keep decision and sequence update for word k, visible after edge c
    function automatic void decide(input int k, input int c);
        logic hit, prv, nxt, wrap, keep;
        logic [7:0] fl;
        exp_t x;
        hit  = |mask_of(k);
        prv  = (k > 0) ? |mask_of(k-1) : 1'b0;
        nxt  = |mask_of(k+1);
        wrap = ((k % 256) == 0);
        keep = hit | prv | nxt | wrap | wtrig[k];
        if (keep && m_state != 2) begin
            fl = {mask_of(k), (m_state == 1), wrap, wtrig[k], hit};
            m_addr = m_addr + 8'd1;
            x.stamp = c;
            x.addr  = m_addr;
            x.data  = {fl, 8'(k % 256), smp(k,3), smp(k,2), smp(k,1), smp(k,0)};
            eq.push_back(x);
            if (m_state == 0 && wtrig[k]) begin
                m_remain = int'(post_periods);
                m_state  = (post_periods == 8'd0) ? 2 : 1;
            end else if (m_state == 1 && wrap) begin
                if (m_remain <= 1) m_state = 2;
                m_remain = m_remain - 1;
            end
        end
    endfunction

    task automatic step(input logic [7:0] a, input logic [7:0] b, input logic t, input logic r);
        smp_a = a; smp_b = b; trig_sync = t; rearm = r;
        wa[cyc] = a; wb[cyc] = b; tcyc[cyc] = t;
        if (cyc % 2 == 1) wtrig[cyc/2] = tcyc[cyc-1] | t;
        if (cyc % 2 == 0 && cyc >= 4) decide((cyc-4)/2, cyc);
        if (r && m_state == 2) m_state = 0;
        cyc++;
        @(negedge clk);
    endtask

    function automatic logic [7:0] rnd_s();
        int r;
        r = int'($urandom % 100);
        if (r < 4) return 8'(8 + ($urandom % 248));
        return 8'($urandom % 8);
    endfunction

    // Output monitor: one time unit after each rising edge
    always @(posedge clk) begin
        #1;
        if (mon_on) begin
            if (wr_en) begin
                if (eq.size() == 0) begin
                    check(1'b0, "R3 R4", "write not due", longint'(wr_addr_a), 0);
                end else begin
                    e = eq.pop_front();
                    check(edge_idx == e.stamp, "R11", "write edge", edge_idx, e.stamp);
                    check(wr_data[31:0] == e.data[31:0], "R1", "samples", wr_data[31:0], e.data[31:0]);
                    check(wr_data[39:32] == e.data[39:32], "R2", "tag", wr_data[39:32], e.data[39:32]);
                    check(wr_data[47:40] == e.data[47:40], "R7", "flags", wr_data[47:40], e.data[47:40]);
                    check(wr_addr_a == e.addr, "R8", "address", wr_addr_a, e.addr);
                end
            end else if (eq.size() > 0 && eq[0].stamp <= edge_idx) begin
                e = eq.pop_front();
                check(1'b0, "R5 R6", "missing write", 0, e.data);
            end
            check(wr_addr_a == wr_addr_b, "R8", "bank copies", wr_addr_b, wr_addr_a);
            check(done == (m_state == 2), "R9", "done flag", done, (m_state == 2));
            edge_idx++;
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        check(1'b0, "R11", "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        logic [7:0] held;
        int n;
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        // R12 reset state
        check(wr_en == 1'b0, "R12", "wr_en in reset", wr_en, 0);
        check(done == 1'b0, "R12", "done in reset", done, 0);
        check(wr_addr_a == 8'hFF, "R12", "address in reset", wr_addr_a, 8'hFF);
        rst_n = 1'b1;
        mon_on = 1'b1;
        post_periods = 8'd0;

        // R3 boundary: value 7 alone is suppressed; R4 neighbours of an 8
        for (int i = 0; i < 60; i++) step(8'd0, 8'd0, 1'b0, 1'b0);
        step(8'd7, 8'd7, 1'b0, 1'b0); step(8'd7, 8'd7, 1'b0, 1'b0);
        for (int i = 0; i < 20; i++) step(8'd3, 8'd0, 1'b0, 1'b0);
        step(8'd0, 8'd0, 1'b0, 1'b0); step(8'd0, 8'd8, 1'b0, 1'b0);
        for (int i = 0; i < 20; i++) step(8'd0, 8'd1, 1'b0, 1'b0);

        // R9 trigger with zero post span freezes on the trigger word
        step(8'd0, 8'd0, 1'b1, 1'b0);
        n = 0;
        while (!done && n < 40) begin step(8'd0, 8'd0, 1'b0, 1'b0); n++; end
        check(done == 1'b1, "R9", "done after zero span", done, 1);
        // R10 triggers and signal ignored while frozen
        held = wr_addr_a;
        for (int i = 0; i < 600; i++) step(8'd200, 8'd9, (i % 50) == 0, 1'b0);
        check(wr_addr_a == held, "R10", "address held when frozen", wr_addr_a, held);
        check(done == 1'b1, "R10", "still frozen", done, 1);
        step(8'd0, 8'd0, 1'b0, 1'b1);
        for (int i = 0; i < 10; i++) step(8'd0, 8'd0, 1'b0, 1'b0);
        check(done == 1'b0, "R10", "rearm clears done", done, 0);

        // R9 one-period post span
        post_periods = 8'd1;
        step(8'd0, 8'd0, 1'b1, 1'b0);
        n = 0;
        while (!done && n < 1200) begin step(rnd_s(), rnd_s(), 1'b0, 1'b0); n++; end
        check(done == 1'b1, "R9", "done after one period", done, 1);
        step(8'd0, 8'd0, 1'b0, 1'b1);

        // Random run: sparse pulses, triggers, rearm while armed and frozen
        n = 0;
        while (cyc < MAXC - 20) begin
            logic t, r;
            t = !done && (($urandom % 1200) == 0);
            r = 1'b0;
            if (done) begin
                n++;
                if (n >= 40) begin
                    r = 1'b1; n = 0;
                    post_periods = 8'($urandom % 3);
                end
            end else if (($urandom % 3000) == 0) r = 1'b1;
            step(rnd_s(), rnd_s(), t, r);
        end

        @(posedge clk); #2;
        mon_on = 1'b0;
        check(eq.size() == 0, "R11", "writes left pending", eq.size(), 0);
        finish_run();
    end

endmodule